// File: doc/BRIEF.md
# Register-Mapped General-Purpose Pin Controller

This block gives software control over up to 32 general-purpose pins through eight 32-bit registers on a simple single-cycle register bus with byte enables. Each pin has the following controls:

- An output register bit drives the pin.
- An active-low output-enable line goes to the pad.
- A per-pin select can hand the pin to an alternate on-chip function in place of the output register.
- An input register holds the captured pin levels.

The input register can be filled in two ways. In the default mode it follows the pins, sampled on the bus clock. In the other mode it is loaded only when a slow external sampling clock makes a chosen edge. Both the pins and the external clock are brought into the bus clock domain through two-flop synchronizers. The pad cells and tristate buffers sit outside the block.

Each pin can raise an interrupt on a rising or a falling transition. A per-pin enable and a global enable gate the event. A hit sets a sticky per-pin status bit and a sticky flag in the control word. The single request line is the flag qualified by the global enable.

Top module: `pin_ctl_top`

## Requirements
- R1: After reset every register reads zero, `pin_out` is zero, `pin_oe_n` is all ones and `irq` is low.
- R2: An access is held with `bus_sel` high; `bus_ack` rises on the next clock for exactly one cycle. Only the byte lanes whose `bus_be` bit is 1 are written. A write to the input register at offset 0x00 is ignored. Register offsets are:
  - 0x00: input
  - 0x04: output
  - 0x08: output enable
  - 0x0C: interrupt enable
  - 0x10: polarity
  - 0x14: alternate select
  - 0x18: control
  - 0x1C: status
- R3: With control bit 0 clear, the input register reads the pin levels once they have been steady for three bus clocks.
- R4: With control bit 0 set and control bit 1 clear, the input register loads the synchronized pins only on a rising edge of `ext_clk`. Pins changing while `ext_clk` is steady leave it unchanged.
- R5: With control bits 0 and 1 both set, loading happens on a falling edge of `ext_clk` instead, and a rising edge has no effect.
- R6: `pin_oe_n` is the bitwise inverse of the output-enable register and changes only when that register is written.
- R7: `pin_out` equals `(alt_in & ALT) | (OUT & ~ALT)`.
- R8: A polarity bit of 1 makes a low-to-high pin transition set that pin's status bit; a 0 makes a high-to-low transition set it.
- R9: A status bit and the flag (control bit 3) are set only while control bit 2 (global enable) and the pin's interrupt-enable bit are both 1.
- R10: `irq` equals control bit 3 AND control bit 2, and is high by the third bus clock after a qualifying pin change.
- R11: Writing zero to the control register drops `irq`. Status bits stay set until software writes them to zero.
- R12: Pins held at a steady level never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle acknowledge |
| pin_in | input | N | Pin levels from the pads |
| alt_in | input | N | Alternate-function output values |
| ext_clk | input | 1 | External sampling clock |
| pin_out | output | N | Values to the pads |
| pin_oe_n | output | N | Active-low output enables |
| irq | output | 1 | Interrupt request |

## Verification
Input capture is tested with several pin patterns, and each pattern is told apart from the one before by checking that the register moves in bus-clock mode. In external-clock mode, new pin values are applied with no sampling edge to show the register holds. Then an edge of the selected kind and an edge of the opposite kind are applied, to show that only the chosen edge loads. Interrupts are tested with all-falling, all-rising and mixed polarity words over bit patterns whose expected status is the per-bit edge kind ANDed with the enable. A separate case applies the same pin toggles with the global enable off, which tells gating apart from detection.

// File: rtl/pin_ctl_pkg.sv
package pin_ctl_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;
    localparam int LANES  = BUS_W / 8;

    typedef enum logic [2:0] {
        IDX_IN   = 3'd0,
        IDX_OUT  = 3'd1,
        IDX_OE   = 3'd2,
        IDX_IEN  = 3'd3,
        IDX_POL  = 3'd4,
        IDX_ALT  = 3'd5,
        IDX_CTL  = 3'd6,
        IDX_STAT = 3'd7
    } reg_idx_e;

    // control word, bit 0 is the last field
    typedef struct packed {
        logic flag;   // bit 3
        logic gie;    // bit 2
        logic fall;   // bit 1
        logic ext;    // bit 0
    } ctl_t;

    function automatic logic [BUS_W-1:0] lane_merge(
        input logic [BUS_W-1:0] old_v,
        input logic [BUS_W-1:0] new_v,
        input logic [LANES-1:0] be
    );
        logic [BUS_W-1:0] res;
        res = old_v;
        for (int b = 0; b < LANES; b++) begin
            if (be[b]) res[8*b +: 8] = new_v[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/pin_ctl_sync.sv
module pin_ctl_sync #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/pin_ctl_sampler.sv
module pin_ctl_sampler #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_s,
    input  logic         ext_s,
    input  logic         use_ext,
    input  logic         on_fall,
    output logic [N-1:0] in_q
);
    typedef struct packed {
        logic [N-1:0] cap;
        logic         ext_prev;
    } st_t;

    st_t  st_d, st_q;
    logic load;

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_s;
        if (!use_ext)     load = 1'b1;
        else if (on_fall) load = st_q.ext_prev & ~ext_s;
        else              load = ~st_q.ext_prev & ext_s;
        if (load) st_d.cap = pin_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_q = st_q.cap;

    // R4: in external mode, no clock transition means no capture
    p_hold_no_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && (ext_s == st_q.ext_prev)) |=> $stable(in_q));

    // R5: falling mode ignores a rising edge
    p_fall_ignores_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && on_fall && ext_s && !st_q.ext_prev) |=> $stable(in_q));
endmodule

// File: rtl/pin_ctl_irq.sv
module pin_ctl_irq #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_s,
    input  logic [N-1:0] ien,
    input  logic [N-1:0] pol,
    input  logic         gie,
    input  logic         stat_we,
    input  logic [N-1:0] stat_wdata,
    output logic [N-1:0] stat_q,
    output logic         hit
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] stat;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] rise, fell, ev;

    always_comb begin
        st_d      = st_q;
        rise      = pin_s & ~st_q.prev;
        fell      = ~pin_s & st_q.prev;
        ev        = ((pol & rise) | (~pol & fell)) & ien & {N{gie}};
        st_d.prev = pin_s;
        st_d.stat = (stat_we ? stat_wdata : st_q.stat) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;
    assign hit    = |ev;

    // R9: with the global enable off, status only moves by software
    p_stat_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && !stat_we) |=> (stat_q == $past(stat_q)));

    // R12: steady synchronized pins set nothing new
    p_steady_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_s == st_q.prev) && !stat_we) |=> (stat_q == $past(stat_q)));
endmodule

// File: rtl/pin_ctl_top.sv
module pin_ctl_top
    import pin_ctl_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ack,
    input  logic [N-1:0]      pin_in,
    input  logic [N-1:0]      alt_in,
    input  logic              ext_clk,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe_n,
    output logic              irq
);
    typedef struct packed {
        logic [N-1:0]     outr;
        logic [N-1:0]     oe;
        logic [N-1:0]     ien;
        logic [N-1:0]     pol;
        logic [N-1:0]     alt;
        ctl_t             ctl;
        logic             ack;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t            r_d, r_q;
    logic [N:0]       sync_q;
    logic [N-1:0]     pin_s, in_q, stat_q;
    logic             ext_s, hit, acc, stat_we;
    logic [N-1:0]     stat_wdata;
    logic [BUS_W-1:0] rd_val, ctl_merged;
    reg_idx_e         idx;

    pin_ctl_sync #(.W(N + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_clk, pin_in}),
        .q     (sync_q)
    );
    assign pin_s = sync_q[N-1:0];
    assign ext_s = sync_q[N];

    pin_ctl_sampler #(.N(N)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s   (pin_s),
        .ext_s   (ext_s),
        .use_ext (r_q.ctl.ext),
        .on_fall (r_q.ctl.fall),
        .in_q    (in_q)
    );

    pin_ctl_irq #(.N(N)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (pin_s),
        .ien        (r_q.ien),
        .pol        (r_q.pol),
        .gie        (r_q.ctl.gie),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .stat_q     (stat_q),
        .hit        (hit)
    );

    assign acc = bus_sel & ~r_q.ack;
    assign idx = reg_idx_e'(bus_addr[ADDR_W-1:2]);

    always_comb begin
        case (idx)
            IDX_IN:   rd_val = BUS_W'(in_q);
            IDX_OUT:  rd_val = BUS_W'(r_q.outr);
            IDX_OE:   rd_val = BUS_W'(r_q.oe);
            IDX_IEN:  rd_val = BUS_W'(r_q.ien);
            IDX_POL:  rd_val = BUS_W'(r_q.pol);
            IDX_ALT:  rd_val = BUS_W'(r_q.alt);
            IDX_CTL:  rd_val = BUS_W'(r_q.ctl);
            default:  rd_val = BUS_W'(stat_q);
        endcase
    end

    always_comb begin
        r_d        = r_q;
        r_d.ack    = acc;
        stat_we    = 1'b0;
        stat_wdata = lane_merge(BUS_W'(stat_q), bus_wdata, bus_be)[N-1:0];
        ctl_merged = lane_merge(BUS_W'(r_q.ctl), bus_wdata, bus_be);
        if (acc && !bus_we) r_d.rdata = rd_val;
        if (acc && bus_we) begin
            case (idx)
                IDX_OUT:  r_d.outr = lane_merge(BUS_W'(r_q.outr), bus_wdata, bus_be)[N-1:0];
                IDX_OE:   r_d.oe   = lane_merge(BUS_W'(r_q.oe),   bus_wdata, bus_be)[N-1:0];
                IDX_IEN:  r_d.ien  = lane_merge(BUS_W'(r_q.ien),  bus_wdata, bus_be)[N-1:0];
                IDX_POL:  r_d.pol  = lane_merge(BUS_W'(r_q.pol),  bus_wdata, bus_be)[N-1:0];
                IDX_ALT:  r_d.alt  = lane_merge(BUS_W'(r_q.alt),  bus_wdata, bus_be)[N-1:0];
                IDX_CTL:  r_d.ctl  = ctl_t'(ctl_merged[3:0]);
                IDX_STAT: stat_we  = 1'b1;
                default:  ;
            endcase
        end
        if (hit) r_d.ctl.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign bus_ack   = r_q.ack;
    assign pin_out   = (alt_in & r_q.alt) | (r_q.outr & ~r_q.alt);
    assign pin_oe_n  = ~r_q.oe;
    assign irq       = r_q.ctl.flag & r_q.ctl.gie;

    // R2: a fresh request is acknowledged on the next clock
    p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ack) |=> bus_ack);

    // R6: enables move only through their own register
    p_oe_only_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && bus_we && idx == IDX_OE) |=> $stable(pin_oe_n));

    // R11: clearing the enable and flag bits silences the request
    p_ctl_clear_drops_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_we && idx == IDX_CTL && bus_be[0] && bus_wdata[3:2] == 2'b00) |=> !irq);
endmodule

// File: tb/pin_ctl_top_test.sv
module pin_ctl_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ack;
    logic [N-1:0]  pin_in = '0, alt_in = '0;
    logic          ext_clk = 1'b0;
    logic [N-1:0]  pin_out, pin_oe_n;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pin_ctl_top #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .pin_in(pin_in),
        .alt_in(alt_in), .ext_clk(ext_clk), .pin_out(pin_out),
        .pin_oe_n(pin_oe_n), .irq(irq)
    );

    localparam logic [4:0] A_IN = 5'h00, A_OUT = 5'h04, A_OE = 5'h08, A_IEN = 5'h0C,
                           A_POL = 5'h10, A_ALT = 5'h14, A_CTL = 5'h18, A_STAT = 5'h1C;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic we, input logic [4:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        chk("R2 ack raised", {31'd0, bus_ack}, 32'd1);
        rd = bus_rdata;
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        chk("R2 ack single cycle", {31'd0, bus_ack}, 32'd0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b1, a, d, 4'hF, dummy);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        xfer(1'b0, a, 32'd0, 4'h0, v);
    endtask

    task automatic t_reset_r1;
        logic [31:0] v;
        chk("R1 pin_out", pin_out, 32'd0);
        chk("R1 pin_oe_n", pin_oe_n, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            chk("R1 register zero", v, 32'd0);
        end
    endtask

    task automatic t_bus_r2;
        logic [31:0] v, dummy;
        wr(A_OUT, 32'h1122_3344);
        xfer(1'b1, A_OUT, 32'hAABB_CCDD, 4'b0101, dummy);
        rd(A_OUT, v);
        chk("R2 byte lanes", v, 32'h11BB_33DD);
        wr(A_IN, 32'hFFFF_FFFF);
        rd(A_IN, v);
        chk("R2 input register read-only", v, 32'd0);
        wr(A_OUT, 32'd0);
    endtask

    task automatic t_sample_bus_r3;
        logic [31:0] v;
        logic [31:0] pats [4] = '{32'hA5A5_0F0F, 32'h5A5A_F0F0, 32'hFFFF_FFFF, 32'h0000_0001};
        wr(A_CTL, 32'd0);
        foreach (pats[i]) begin
            pin_in = pats[i];
            wait_cyc(3);
            rd(A_IN, v);
            chk("R3 bus-clock sampling", v, pats[i]);
        end
    endtask

    task automatic t_ext_r4_r5;
        logic [31:0] v;
        ext_clk = 1'b0;
        pin_in = 32'h1357_9BDF;
        wait_cyc(4);
        wr(A_CTL, 32'h1);
        pin_in = 32'hCAFE_0001;
        wait_cyc(5);
        rd(A_IN, v);
        chk("R4 hold without edge", v, 32'h1357_9BDF);
        ext_clk = 1'b1;
        wait_cyc(5);
        rd(A_IN, v);
        chk("R4 rising edge loads", v, 32'hCAFE_0001);
        pin_in = 32'h0F0F_1234;
        wait_cyc(5);
        rd(A_IN, v);
        chk("R4 pins change, no edge", v, 32'hCAFE_0001);
        wr(A_CTL, 32'h3);
        pin_in = 32'h8000_7777;
        wait_cyc(4);
        ext_clk = 1'b0;
        wait_cyc(5);
        rd(A_IN, v);
        chk("R5 falling edge loads", v, 32'h8000_7777);
        pin_in = 32'h2222_4444;
        wait_cyc(4);
        ext_clk = 1'b1;
        wait_cyc(5);
        rd(A_IN, v);
        chk("R5 rising edge ignored", v, 32'h8000_7777);
        ext_clk = 1'b0;
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_oe_r6;
        logic [31:0] pats [3] = '{32'h0000_FFFF, 32'hDEAD_BEEF, 32'd0};
        foreach (pats[i]) begin
            wr(A_OE, pats[i]);
            chk("R6 active-low enables", pin_oe_n, ~pats[i]);
        end
    endtask

    task automatic t_alt_r7;
        logic [31:0] ai [3] = '{32'hFFFF_0000, 32'h1234_5678, 32'hAAAA_AAAA};
        logic [31:0] al [3] = '{32'h00FF_00FF, 32'hFFFF_FFFF, 32'h0F0F_F0F0};
        logic [31:0] ou [3] = '{32'hF0F0_F0F0, 32'h0000_0000, 32'h5555_5555};
        foreach (ai[i]) begin
            alt_in = ai[i];
            wr(A_ALT, al[i]);
            wr(A_OUT, ou[i]);
            chk("R7 output mux", pin_out, (ai[i] & al[i]) | (ou[i] & ~al[i]));
        end
        wr(A_ALT, 32'd0);
        wr(A_OUT, 32'd0);
    endtask

    // one interrupt scenario: settle pins at p0, arm, move to p1
    task automatic irq_case(input string tag, input logic [31:0] p0, input logic [31:0] p1,
                            input logic [31:0] pol, input logic [31:0] en);
        logic [31:0] v, exp;
        exp = ((pol & p1 & ~p0) | (~pol & ~p1 & p0)) & en;
        pin_in = p0;
        wait_cyc(4);
        wr(A_CTL, 32'h0);
        wr(A_STAT, 32'h0);
        wr(A_POL, pol);
        wr(A_IEN, en);
        wr(A_CTL, 32'h4);
        wait_cyc(5);
        chk({tag, " R12 steady pins quiet"}, {31'd0, irq}, 32'd0);
        pin_in = p1;
        wait_cyc(3);
        chk({tag, " R10 irq within three clocks"}, {31'd0, irq}, {31'd0, exp != 0});
        wait_cyc(2);
        wr(A_CTL, 32'h0);
        chk({tag, " R11 control clear drops irq"}, {31'd0, irq}, 32'd0);
        rd(A_STAT, v);
        chk({tag, " R8 status after edge"}, v, exp);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v);
        chk({tag, " R11 status cleared by write"}, v, 32'd0);
    endtask

    task automatic t_irq_r8_r9;
        logic [31:0] v;
        irq_case("fall", 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 32'hFFFF_FFFF);
        irq_case("rise", 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        irq_case("mixed", 32'h00FF_00FF, 32'hFF00_0FF0, 32'h0000_FFFF, 32'hFFFF_FFFF);
        irq_case("R9 enable mask", 32'h0000_0000, 32'h0000_0028, 32'hFFFF_FFFF, 32'h0000_0008);
        irq_case("R9 no enabled edge", 32'h0000_0000, 32'h0000_0020, 32'hFFFF_FFFF, 32'h0000_0008);
        // global enable off: toggles set nothing
        pin_in = 32'h0;
        wait_cyc(4);
        wr(A_POL, 32'hFFFF_FFFF);
        wr(A_IEN, 32'hFFFF_FFFF);
        wr(A_CTL, 32'h0);
        pin_in = 32'hFFFF_FFFF;
        wait_cyc(5);
        chk("R9 global off irq", {31'd0, irq}, 32'd0);
        rd(A_STAT, v);
        chk("R9 global off status", v, 32'd0);
        rd(A_CTL, v);
        chk("R9 global off flag", v, 32'd0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset_r1();
        t_bus_r2();
        t_sample_bus_r3();
        t_ext_r4_r5();
        t_oe_r6();
        t_alt_r7();
        t_irq_r8_r9();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule